// File: doc/BRIEF.md
# Synchronous Word Data Memory with Marker Reads

This block is the data store of a small load/store processor. It holds 32-bit words behind a byte-addressed window of 16 KiB. An access is started by raising the request strobe. The write-enable input selects a store or a load. The low two address bits are discarded, so every byte address inside a word reaches that word.

The read port is registered. The value on `rdata_o` always reflects the access sampled at the previous rising edge. Only a load that hits the window returns stored data. All other cycles load a fixed marker into the output register:

- An idle cycle or a store loads the "no read" marker 0xFA11_1EAF.
- A load outside the window loads the "bad address" marker 0xDEAD_BEEF.

A small cycle-classifying state machine registers what kind of access was sampled. The output mapping is then driven from that state.

States and transitions: `ST_RESET` is held while reset is asserted. On every edge out of reset, the next state is chosen from the sampled inputs:

- `ST_IDLE` is chosen when the request is low.
- `ST_WRITE` is chosen when the request and write enable are both high.
- `ST_READ` is chosen for a load whose address is below 16384.
- `ST_RANGE_ERR` is chosen for a load at or above 16384.

Any state can move to any other state on the next edge, and any state returns to `ST_RESET` while reset is low.

Top module: `dmem_sync`

## Requirements
- R1: While `rst_ni` is low, each rising edge leaves `rdata_o` at 0.
- R2: On an edge with `req_i`=1, `we_i`=1 and `addr_i` below 16384, `wdata_i` is stored in word `addr_i[13:2]`. A later load of that word returns it.
- R3: On an edge with `req_i`=0, `rdata_o` becomes 0xFA111EAF after that edge, whatever `we_i` is.
- R4: On an edge with `req_i`=1 and `we_i`=1, `rdata_o` becomes 0xFA111EAF after that edge.
- R5: On an edge with `req_i`=1, `we_i`=0 and a 32-bit `addr_i` of 16384 or more, `rdata_o` becomes 0xDEADBEEF after that edge.
- R6: On an edge with `req_i`=1, `we_i`=0 and `addr_i` below 16384, `rdata_o` shows word `addr_i[13:2]` after that edge. It does not change before that edge.
- R7: `addr_i[1:0]` has no effect on which word is read; byte addresses 4k to 4k+3 all return word k.
- R8: Byte addresses 16380 to 16383 read word 4095 as data, not the bad-address marker.
- R9: A load does not change memory; repeated loads of a word return the same value.
- R10: A store at or above 16384 changes no word; in particular the word selected by its low address bits is untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low synchronous reset of the output register |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, full word |
| rdata_o | output | 32 | Registered load data or marker |

## Verification
The assertions assume the following about the inputs:

- `req_i`, `we_i` and `addr_i` are known values at every sampled edge once reset is released.
- Reset is applied before the first access.

The stimulus keeps to these assumptions by driving every input just after a rising edge and holding it for a full period. It also keeps reset low for the first cycles, and it never leaves an input undriven. Memory words start undefined, so every word is written before any load of it is compared against the model.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Marker values loaded into the read register when no stored word is returned
    localparam logic [31:0] NO_READ_MARK  = 32'hFA11_1EAF;
    localparam logic [31:0] BAD_ADDR_MARK = 32'hDEAD_BEEF;

    // Class of the access sampled at the last edge
    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_IDLE      = 3'd1,
        ST_WRITE     = 3'd2,
        ST_READ      = 3'd3,
        ST_RANGE_ERR = 3'd4
    } cyc_state_e;

endpackage

// File: rtl/dmem_addr_decode.sv
module dmem_addr_decode #(
    parameter int ADDR_W      = 32,
    parameter int DEPTH_WORDS = 4096,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_range_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH_WORDS * 4);

    // Whole address is compared, so high bits never alias into the window
    assign in_range_o = (addr_i < LIMIT);
    // Byte lane bits are dropped
    assign idx_o      = addr_i[IDX_W+1:2];
endmodule

// File: rtl/dmem_cycle_fsm.sv
module dmem_cycle_fsm
    import dmem_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       req_i,
    input  logic       we_i,
    input  logic       in_range_i,
    output cyc_state_e state_q_o,
    output logic       wr_en_o
);
    cyc_state_e state_d;
    cyc_state_e state_q;

    always_comb begin
        state_d = ST_IDLE;
        unique casez ({req_i, we_i, in_range_i})
            3'b0??:  state_d = ST_IDLE;
            3'b11?:  state_d = ST_WRITE;
            3'b101:  state_d = ST_READ;
            3'b100:  state_d = ST_RANGE_ERR;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_q_o = state_q;
    // A store lands only inside the window and never during reset
    assign wr_en_o   = rst_ni && req_i && we_i && in_range_i;
endmodule

// File: rtl/dmem_store.sv
module dmem_store #(
    parameter int DATA_W      = 32,
    parameter int DEPTH_WORDS = 4096,
    localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rword_q_o
);
    logic [DATA_W-1:0] mem_q [DEPTH_WORDS];
    logic [DATA_W-1:0] rword_q;

    // Single port array with registered read, suited to block RAM
    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem_q[idx_i] <= wdata_i;
        end
        rword_q <= mem_q[idx_i];
    end

    assign rword_q_o = rword_q;
endmodule

// File: rtl/dmem_rd_mux.sv
module dmem_rd_mux
    import dmem_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cyc_state_e        state_q_i,
    input  logic [DATA_W-1:0] rword_q_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (state_q_i)
            ST_RESET:     rdata_o = '0;
            ST_IDLE:      rdata_o = DATA_W'(NO_READ_MARK);
            ST_WRITE:     rdata_o = DATA_W'(NO_READ_MARK);
            ST_READ:      rdata_o = rword_q_i;
            ST_RANGE_ERR: rdata_o = DATA_W'(BAD_ADDR_MARK);
            default:      rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dmem_sync.sv
module dmem_sync
    import dmem_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int DEPTH_WORDS = 4096
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int IDX_W = $clog2(DEPTH_WORDS);

    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic             wr_en;
    cyc_state_e       state_q;
    logic [DATA_W-1:0] rword_q;

    dmem_addr_decode #(
        .ADDR_W      (ADDR_W),
        .DEPTH_WORDS (DEPTH_WORDS)
    ) u_decode (
        .addr_i     (addr_i),
        .in_range_o (in_range),
        .idx_o      (idx)
    );

    dmem_cycle_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i),
        .we_i       (we_i),
        .in_range_i (in_range),
        .state_q_o  (state_q),
        .wr_en_o    (wr_en)
    );

    dmem_store #(
        .DATA_W      (DATA_W),
        .DEPTH_WORDS (DEPTH_WORDS)
    ) u_store (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en),
        .idx_i     (idx),
        .wdata_i   (wdata_i),
        .rword_q_o (rword_q)
    );

    dmem_rd_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .state_q_i (state_q),
        .rword_q_i (rword_q),
        .rdata_o   (rdata_o)
    );
endmodule

// File: rtl/dmem_sync_chk.sv
module dmem_sync_chk #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 32,
    parameter int DEPTH_WORDS = 4096
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_i,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(DEPTH_WORDS * 4);

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        !rst_ni |=> rdata_o == '0); // R1

    AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> rdata_o == DATA_W'(32'hFA11_1EAF)); // R3

    AST_WRITE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && we_i) |=> rdata_o == DATA_W'(32'hFA11_1EAF)); // R4

    AST_RANGE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && addr_i >= LIMIT) |=> rdata_o == DATA_W'(32'hDEAD_BEEF)); // R5
endmodule

bind dmem_sync dmem_sync_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .DEPTH_WORDS (DEPTH_WORDS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o)
);

// File: tb/dmem_sync_bench.sv
`timescale 1ns/1ps
module dmem_sync_bench;
    localparam int WORDS = 4096;
    localparam logic [31:0] M_IDLE = 32'hFA11_1EAF;
    localparam logic [31:0] M_BAD  = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] model [WORDS];
    bit          known [WORDS];

    always #2.5 clk = ~clk;

    dmem_sync u_dmem_sync (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .we_i    (we),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rdata=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, wait for edge, update model, compare
    task automatic cyc(input logic r, input logic w, input logic [31:0] a,
                       input logic [31:0] d, input string tag_in);
        logic [31:0] exp;
        string tag;
        bit cmp;
        int k;
        req = r; we = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        cmp = 1'b1;
        tag = tag_in;
        k = int'(a[13:2]);
        if (!r) begin
            exp = M_IDLE; if (tag == "") tag = "R3";
        end else if (w) begin
            exp = M_IDLE; if (tag == "") tag = "R4";
            if (a < 32'd16384) begin
                model[k] = d; known[k] = 1'b1;
            end
        end else if (a >= 32'd16384) begin
            exp = M_BAD; if (tag == "") tag = "R5";
        end else begin
            exp = model[k];
            cmp = known[k];
            if (tag == "") tag = (k == WORDS-1) ? "R8" : (a[1:0] != 2'b00) ? "R7" : "R6";
        end
        if (cmp) check(tag, rdata, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: rdata=%h expected=completion", rdata);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) known[i] = 1'b0;
        // R1: reset holds output at zero
        for (int i = 0; i < 3; i++) begin
            req = 1'b1; we = 1'b0; addr = 32'h0001_0000;
            @(posedge clk); #1;
            check("R1", rdata, 32'h0);
        end
        rst_n = 1'b1;
        // R2/R4: fill every word
        for (int i = 0; i < WORDS; i++)
            cyc(1'b1, 1'b1, 32'(i * 4), 32'(i) * 32'h9E37_79B9 + 32'd1, "R4");
        // R6: plain loads, and synchronous latency
        cyc(1'b1, 1'b0, 32'd0, 32'd0, "R6");
        cyc(1'b1, 1'b0, 32'd4, 32'd0, "R6");
        req = 1'b1; we = 1'b0; addr = 32'd8;
        #1; check("R6", rdata, model[1]);
        cyc(1'b1, 1'b0, 32'd8, 32'd0, "R6");
        // R7: byte lanes ignored
        cyc(1'b1, 1'b0, 32'd13, 32'd0, "R7");
        cyc(1'b1, 1'b0, 32'd14, 32'd0, "R7");
        cyc(1'b1, 1'b0, 32'd15, 32'd0, "R7");
        // R8: top of window
        cyc(1'b1, 1'b0, 32'd16383, 32'd0, "R8");
        cyc(1'b1, 1'b0, 32'd16380, 32'd0, "R8");
        // R5: out of window
        cyc(1'b1, 1'b0, 32'd16384, 32'd0, "R5");
        cyc(1'b1, 1'b0, 32'hFFFF_FFFC, 32'd0, "R5");
        cyc(1'b1, 1'b0, 32'h0001_0008, 32'd0, "R5");
        // R3: idle with either write enable
        cyc(1'b0, 1'b0, 32'd4, 32'd0, "R3");
        cyc(1'b0, 1'b1, 32'd4, 32'h5555_AAAA, "R3");
        cyc(1'b1, 1'b0, 32'd4, 32'd0, "R3");
        // R10: store outside window leaves aliased word alone
        cyc(1'b1, 1'b1, 32'd16384 + 32'd8, 32'h1234_5678, "R4");
        cyc(1'b1, 1'b0, 32'd8, 32'd0, "R10");
        cyc(1'b1, 1'b1, 32'h8000_0008, 32'h8765_4321, "R4");
        cyc(1'b1, 1'b0, 32'd8, 32'd0, "R10");
        // R2 then R9: store, load, reload
        cyc(1'b1, 1'b1, 32'd20, 32'hCAFE_0123, "R4");
        cyc(1'b1, 1'b0, 32'd20, 32'd0, "R2");
        cyc(1'b1, 1'b0, 32'd21, 32'd0, "R9");
        cyc(1'b1, 1'b0, 32'd20, 32'd0, "R9");
        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = ($urandom_range(0, 7) == 0) ? (32'd16384 + $urandom_range(0, 65535))
                                            : 32'($urandom_range(0, 16383));
            cyc($urandom_range(0, 9) != 0, $urandom_range(0, 2) == 0, a, $urandom, "");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule